// File: doc/BRIEF.md
# Linked Descriptor Fetch Sequencer

This block sits in front of the transfer engine of a DMA channel and walks a chain of descriptors held in memory. A one-cycle start pulse carries the 64-bit address of the first descriptor. The sequencer reads every 64-byte descriptor as sixteen 32-bit words through a simple request/response read port. It decodes the words into a segment made of ID, addresses, 2D lengths and strides, and offers that segment on a valid/ready output. It then moves on to the address held in the descriptor's next field.

Each descriptor carries two control flags in its first word. One flag ends the chain after that descriptor. The other asks for an interrupt pulse once the segment has been handed over. A ring of descriptors whose final next field points back to the head, with the end flag cleared everywhere, keeps the sequencer running indefinitely. While one segment waits on the output, the following descriptor is fetched, but never more than one. A read error stops the walk and raises a sticky error flag, which the next accepted start clears.

Top module: `desc_chain_fetch`

## Requirements
- R1: Out of reset, segValid, rdReq, busy, irqPulse and errFlag are all low.
- R2: A start pulse taken while idle fetches the head descriptor by reading addresses head+4*k for k = 0..15 in increasing order. Only one read is outstanding at a time, and rdReq and rdAddr hold steady until rdGnt.
- R3: Word decode. Word 0 holds the flags (bit 0 = end of chain, bit 1 = interrupt request, other bits ignored). Word 1 is the ID. Words 2/3 are the destination address, 4/5 the source address and 6/7 the next address, each low word first. Word 8 is the Y length, word 9 the X length, word 10 the source stride and word 11 the destination stride. Words 12 to 15 are read and discarded.
- R4: A segment appears on the output only after all 16 words of its descriptor have arrived. Its fields and segValid hold steady while segReady is low.
- R5: After a segment whose end flag is set, no further reads are issued, and busy falls once the output is accepted.
- R6: A descriptor with the end flag clear is followed by a fetch at its next address, so a ring whose last next field points at its head keeps producing segments.
- R7: irqPulse is high for exactly one cycle, the cycle after a segment whose interrupt flag is set is accepted. It never pulses otherwise.
- R8: While the output segment is not accepted, exactly one following descriptor is fetched, and after that rdReq stays low until the output is accepted.
- R9: A read response with rdErr high ends fetching, sets errFlag and issues no more reads. A later accepted start clears errFlag.
- R10: A start pulse while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain at headAddr |
| headAddr | input | 64 | Address of first descriptor |
| busy | output | 1 | Chain walk or output segment in progress |
| rdReq | output | 1 | Read request |
| rdAddr | output | 64 | Read word address |
| rdGnt | input | 1 | Read request accepted |
| rdValid | input | 1 | Read response valid |
| rdData | input | 32 | Read response data |
| rdErr | input | 1 | Read response error |
| segValid | output | 1 | Segment available |
| segReady | input | 1 | Transfer engine takes the segment |
| segId | output | 32 | ID of the current segment |
| segDst | output | 64 | Destination address |
| segSrc | output | 64 | Source address |
| segXLen | output | 32 | X length field |
| segYLen | output | 32 | Y length field |
| segSrcStride | output | 32 | Source stride |
| segDstStride | output | 32 | Destination stride |
| irqPulse | output | 1 | Completion interrupt pulse |
| errFlag | output | 1 | Sticky read-error flag |

## Verification
A wrong word index or a stale address register shows up on the very next read, as an address out of sequence. A scoreboard of expected read addresses therefore catches it within one read. A fault in field capture or promotion shows as a mismatched segment at the first handshake after that descriptor. Wrong end-flag or next-pointer handling shows as reads the scoreboard never expected. A broken prefetch limit shows as rdReq rising while the output is stalled, which a held-off segReady exposes within one descriptor time.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;

  // word positions inside one descriptor
  localparam int W_FLAGS   = 0;
  localparam int W_ID      = 1;
  localparam int W_DST     = 2;
  localparam int W_SRC     = 4;
  localparam int W_NEXT    = 6;
  localparam int W_YLEN    = 8;
  localparam int W_XLEN    = 9;
  localparam int W_SSTRIDE = 10;
  localparam int W_DSTRIDE = 11;

  typedef struct packed {
    logic [WORD_W-1:0] id;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] nxt;
    logic [WORD_W-1:0] yLen;
    logic [WORD_W-1:0] xLen;
    logic [WORD_W-1:0] srcStride;
    logic [WORD_W-1:0] dstStride;
    logic              irq;
    logic              last;
  } desc_t;

  typedef struct packed {
    logic loadHead;
    logic followNext;
    logic capture;
    logic promote;
  } strobe_t;
endpackage

// File: rtl/desc_chain_dp.sv
module desc_chain_dp
  import desc_chain_pkg::*;
#(
  parameter int DESC_WORDS = 16,
  localparam int IDX_W = $clog2(DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] headAddr,
  input  logic [WORD_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              stagedLast,
  output logic              outIrq,
  output logic [WORD_W-1:0] outId,
  output logic [ADDR_W-1:0] outDst,
  output logic [ADDR_W-1:0] outSrc,
  output logic [WORD_W-1:0] outXLen,
  output logic [WORD_W-1:0] outYLen,
  output logic [WORD_W-1:0] outSrcStride,
  output logic [WORD_W-1:0] outDstStride
);
  logic [ADDR_W-1:0] descAddr;
  desc_t             staged;

  assign rdAddr     = descAddr + ADDR_W'({idx, 2'b00});
  assign stagedLast = staged.last;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr <= '0;
    end else if (stb.loadHead) begin
      descAddr <= headAddr;
    end else if (stb.followNext) begin
      descAddr <= staged.nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staged <= '0;
    end else if (stb.capture) begin
      case (idx)
        IDX_W'(W_FLAGS): begin
          staged.last <= rdData[0];
          staged.irq  <= rdData[1];
        end
        IDX_W'(W_ID):          staged.id              <= rdData;
        IDX_W'(W_DST):         staged.dst[31:0]       <= rdData;
        IDX_W'(W_DST + 1):     staged.dst[63:32]      <= rdData;
        IDX_W'(W_SRC):         staged.src[31:0]       <= rdData;
        IDX_W'(W_SRC + 1):     staged.src[63:32]      <= rdData;
        IDX_W'(W_NEXT):        staged.nxt[31:0]       <= rdData;
        IDX_W'(W_NEXT + 1):    staged.nxt[63:32]      <= rdData;
        IDX_W'(W_YLEN):        staged.yLen            <= rdData;
        IDX_W'(W_XLEN):        staged.xLen            <= rdData;
        IDX_W'(W_SSTRIDE):     staged.srcStride       <= rdData;
        IDX_W'(W_DSTRIDE):     staged.dstStride       <= rdData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outIrq       <= 1'b0;
      outId        <= '0;
      outDst       <= '0;
      outSrc       <= '0;
      outXLen      <= '0;
      outYLen      <= '0;
      outSrcStride <= '0;
      outDstStride <= '0;
    end else if (stb.promote) begin
      outIrq       <= staged.irq;
      outId        <= staged.id;
      outDst       <= staged.dst;
      outSrc       <= staged.src;
      outXLen      <= staged.xLen;
      outYLen      <= staged.yLen;
      outSrcStride <= staged.srcStride;
      outDstStride <= staged.dstStride;
    end
  end

  AST_CAPTURE_PROMOTE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.capture && stb.promote)) else $error("capture and promote together"); // R4
endmodule

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl
  import desc_chain_pkg::*;
#(
  parameter int DESC_WORDS = 16,
  localparam int IDX_W = $clog2(DESC_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             rdGnt,
  input  logic             rdValid,
  input  logic             rdErr,
  input  logic             segReady,
  input  logic             stagedLast,
  input  logic             outIrq,
  output strobe_t          stb,
  output logic [IDX_W-1:0] idx,
  output logic             rdReq,
  output logic             segValid,
  output logic             irqPulse,
  output logic             errFlag,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FULL} state_t;
  state_t state;

  logic segFire, slotFree, takeStart;
  assign segFire   = segValid && segReady;
  assign slotFree  = !segValid || segFire;
  assign takeStart = (state == S_IDLE) && start && !segValid;
  assign rdReq     = (state == S_REQ);
  assign busy      = (state != S_IDLE) || segValid;

  always_comb begin
    stb = '0;
    case (state)
      S_IDLE: stb.loadHead = takeStart;
      S_WAIT: stb.capture  = rdValid && !rdErr;
      S_FULL: begin
        stb.promote    = slotFree;
        stb.followNext = slotFree && !stagedLast;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      errFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (takeStart) begin
          errFlag <= 1'b0;
          idx     <= '0;
          state   <= S_REQ;
        end
        S_REQ: if (rdGnt) state <= S_WAIT;
        S_WAIT: if (rdValid) begin
          if (rdErr) begin
            errFlag <= 1'b1;
            state   <= S_IDLE;
          end else if (idx == LAST_IDX) begin
            state <= S_FULL;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_REQ;
          end
        end
        S_FULL: if (slotFree) begin
          idx   <= '0;
          state <= stagedLast ? S_IDLE : S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segValid <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (stb.promote)  segValid <= 1'b1;
      else if (segFire) segValid <= 1'b0;
      irqPulse <= segFire && outIrq;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdGnt |=> rdReq) else $error("request dropped"); // R2
  AST_ONE_AHEAD: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FULL) && segValid && !segReady |=> !rdReq) else $error("fetched two ahead"); // R8
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FULL) && slotFree && stagedLast |=> !rdReq) else $error("read after end"); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(segFire)) else $error("spurious irq"); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !rdReq) else $error("read after error"); // R9
endmodule

// File: rtl/desc_chain_fetch.sv
module desc_chain_fetch
  import desc_chain_pkg::*;
#(
  parameter int DESC_WORDS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] headAddr,
  output logic        busy,
  output logic        rdReq,
  output logic [63:0] rdAddr,
  input  logic        rdGnt,
  input  logic        rdValid,
  input  logic [31:0] rdData,
  input  logic        rdErr,
  output logic        segValid,
  input  logic        segReady,
  output logic [31:0] segId,
  output logic [63:0] segDst,
  output logic [63:0] segSrc,
  output logic [31:0] segXLen,
  output logic [31:0] segYLen,
  output logic [31:0] segSrcStride,
  output logic [31:0] segDstStride,
  output logic        irqPulse,
  output logic        errFlag
);
  localparam int IDX_W = $clog2(DESC_WORDS);

  strobe_t          stb;
  logic [IDX_W-1:0] idx;
  logic             stagedLast, outIrq;

  desc_chain_ctrl #(.DESC_WORDS(DESC_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdGnt(rdGnt), .rdValid(rdValid),
    .rdErr(rdErr), .segReady(segReady), .stagedLast(stagedLast), .outIrq(outIrq),
    .stb(stb), .idx(idx), .rdReq(rdReq), .segValid(segValid),
    .irqPulse(irqPulse), .errFlag(errFlag), .busy(busy)
  );

  desc_chain_dp #(.DESC_WORDS(DESC_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .headAddr(headAddr),
    .rdData(rdData), .rdAddr(rdAddr), .stagedLast(stagedLast), .outIrq(outIrq),
    .outId(segId), .outDst(segDst), .outSrc(segSrc), .outXLen(segXLen),
    .outYLen(segYLen), .outSrcStride(segSrcStride), .outDstStride(segDstStride)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdGnt |=> $stable(rdAddr)) else $error("address moved"); // R2
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid && $stable(segId) && $stable(segDst) && $stable(segXLen))
    else $error("segment moved"); // R4
endmodule

// File: tb/desc_chain_fetch_test.sv
module desc_chain_fetch_test;
  logic        clk = 1'b0;
  logic        rstN, start, rdGnt, rdValid, rdErr, segReady;
  logic [63:0] headAddr;
  logic [31:0] rdData;
  logic        busy, rdReq, segValid, irqPulse, errFlag;
  logic [63:0] rdAddr, segDst, segSrc;
  logic [31:0] segId, segXLen, segYLen, segSrcStride, segDstStride;

  always #5 clk = ~clk;

  desc_chain_fetch uut (.*);

  int checks = 0;
  int failures = 0;

  logic [31:0]  mem [logic [63:0]];
  logic [63:0]  addrQ [$];
  logic [287:0] segQ [$];
  logic         irqQ [$];
  logic [63:0]  errAddr = '0;
  int           errOn = 0;
  int           errCount = 0;
  bit           errArmed = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic putDesc(input logic [63:0] a, input logic [1:0] flg,
      input logic [31:0] id, input logic [63:0] dst, input logic [63:0] src,
      input logic [63:0] nxt, input logic [31:0] yl, input logic [31:0] xl,
      input logic [31:0] ss, input logic [31:0] ds);
    mem[a]      = {30'h2b5a_c3d1, flg};
    mem[a + 4]  = id;
    mem[a + 8]  = dst[31:0];  mem[a + 12] = dst[63:32];
    mem[a + 16] = src[31:0];  mem[a + 20] = src[63:32];
    mem[a + 24] = nxt[31:0];  mem[a + 28] = nxt[63:32];
    mem[a + 32] = yl;  mem[a + 36] = xl;
    mem[a + 40] = ss;  mem[a + 44] = ds;
    for (int k = 12; k < 16; k++) mem[a + 64'(4 * k)] = 32'hdead_0000 + 32'(k);
  endtask

  // R3: expected segment decoded from the word positions
  task automatic expectVisit(input logic [63:0] a);
    for (int k = 0; k < 16; k++) addrQ.push_back(a + 64'(4 * k));
    segQ.push_back({rd(a + 4), rd(a + 12), rd(a + 8), rd(a + 20), rd(a + 16),
                    rd(a + 36), rd(a + 32), rd(a + 40), rd(a + 44)});
    irqQ.push_back(rd(a)[1]);
  endtask

  // memory model and read-address scoreboard
  initial begin
    logic [63:0] pendAddr;
    bit rspPend;
    rspPend = 0; pendAddr = '0;
    rdGnt = 0; rdValid = 0; rdData = '0; rdErr = 0;
    forever begin
      @(negedge clk);
      rdGnt = 0; rdValid = 0; rdErr = 0;
      if (rspPend) begin
        rdValid = 1;
        rdData  = rd(pendAddr);
        if (errArmed && pendAddr == errAddr) begin
          errCount++;
          if (errCount == errOn) begin rdErr = 1; rdData = '0; end
        end
        rspPend = 0;
      end else if (rdReq && rstN) begin
        rdGnt = 1; pendAddr = rdAddr; rspPend = 1;
        if (addrQ.size() == 0)
          chk(0, "R5", "unexpected read", rdAddr, 64'h0);
        else begin
          logic [63:0] e;
          e = addrQ.pop_front();
          chk(rdAddr == e, "R2", "read address", rdAddr, e);
        end
      end
    end
  end

  // segment and irq monitor
  initial begin
    logic lastIrq;
    lastIrq = 0;
    forever begin
      @(negedge clk); #1;
      if (rstN) begin
        if (irqPulse || lastIrq)
          chk(irqPulse == lastIrq, "R7", "irq pulse", 64'(irqPulse), 64'(lastIrq));
        lastIrq = 0;
        if (segValid && segReady) begin
          if (segQ.size() == 0)
            chk(0, "R6", "unexpected segment", 64'(segId), 64'h0);
          else begin
            logic [287:0] e, a;
            e = segQ.pop_front();
            a = {segId, segDst, segSrc, segXLen, segYLen, segSrcStride, segDstStride};
            chk(a == e, "R3", "segment fields", a[63:0], e[63:0]);
            if (a != e) $display("  id act=%h exp=%h", a[287:256], e[287:256]);
            lastIrq = irqQ.pop_front();
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic pulseStart(input logic [63:0] a);
    @(negedge clk);
    start = 1; headAddr = a;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitIdle(input string req);
    int n;
    n = 0;
    @(negedge clk); @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(!busy, req, "busy falls", 64'(busy), 64'h0);
    chk(addrQ.size() == 0, req, "reads left", 64'(addrQ.size()), 64'h0);
    chk(segQ.size() == 0, req, "segments left", 64'(segQ.size()), 64'h0);
  endtask

  initial begin
    rstN = 0; start = 0; headAddr = '0; segReady = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(!segValid && !rdReq && !busy && !irqPulse && !errFlag, "R1", "reset outputs",
        {59'h0, segValid, rdReq, busy, irqPulse, errFlag}, 64'h0);
    @(negedge clk);
    rstN = 1;

    // linear chain of three, irq on the last two (R2 R3 R5 R7 R10)
    putDesc(64'h1000, 2'b00, 32'h11, 64'h1_0000_0100, 64'h2_0000_0200, 64'h1040,
            32'h3, 32'h7f, 32'h80, 32'h100);
    putDesc(64'h1040, 2'b10, 32'h22, 64'h0000_0000_a000, 64'h5_0000_b000, 64'h2000,
            32'h0, 32'hfff, 32'h0, 32'h0);
    putDesc(64'h2000, 2'b11, 32'h33, 64'hffff_ffff_0000_0040, 64'h40, 64'h9999_0000,
            32'h1, 32'h3f, 32'h40, 32'h80);
    expectVisit(64'h1000); expectVisit(64'h1040); expectVisit(64'h2000);
    pulseStart(64'h1000);
    repeat (6) @(negedge clk);
    pulseStart(64'h9000);   // R10: ignored, any read there fails the scoreboard
    waitIdle("R5");
    repeat (20) @(negedge clk);
    chk(!rdReq, "R5", "no reads after end", 64'(rdReq), 64'h0);

    // back-pressure: one descriptor ahead only (R4 R8)
    putDesc(64'h4000, 2'b00, 32'h44, 64'h400, 64'h800, 64'h4100,
            32'h2, 32'h10, 32'h20, 32'h30);
    putDesc(64'h4100, 2'b01, 32'h55, 64'h500, 64'h900, 64'h0,
            32'h0, 32'h1f, 32'h0, 32'h0);
    expectVisit(64'h4000); expectVisit(64'h4100);
    segReady = 0;
    pulseStart(64'h4000);
    repeat (120) @(negedge clk);
    #1;
    chk(addrQ.size() == 0, "R8", "prefetch done", 64'(addrQ.size()), 64'h0);
    chk(!rdReq, "R8", "no second prefetch", 64'(rdReq), 64'h0);
    chk(segValid && segId == 32'h44, "R4", "held segment id", 64'(segId), 64'h44);
    repeat (20) @(negedge clk);
    #1;
    chk(segValid && segId == 32'h44 && segDst == 64'h400, "R4", "still held", segDst, 64'h400);
    chk(!rdReq, "R8", "still no read", 64'(rdReq), 64'h0);
    @(negedge clk);
    segReady = 1;
    waitIdle("R8");

    // ring of two, stopped by a read error on the fourth head fetch (R6 R9)
    putDesc(64'h3000, 2'b00, 32'h66, 64'h600, 64'h700, 64'h3040,
            32'h0, 32'h7, 32'h0, 32'h0);
    putDesc(64'h3040, 2'b00, 32'h77, 64'h610, 64'h710, 64'h3000,
            32'h0, 32'hf, 32'h0, 32'h0);
    for (int v = 0; v < 3; v++) begin expectVisit(64'h3000); expectVisit(64'h3040); end
    addrQ.push_back(64'h3000);
    errAddr = 64'h3000; errOn = 4; errCount = 0; errArmed = 1;
    pulseStart(64'h3000);
    waitIdle("R6");
    chk(errFlag, "R9", "error flag set", 64'(errFlag), 64'h1);
    repeat (20) @(negedge clk);
    chk(!rdReq && errFlag, "R9", "fetch stopped", 64'(rdReq), 64'h0);
    errArmed = 0;

    // new start clears the error (R9)
    putDesc(64'h5000, 2'b11, 32'h88, 64'h1234, 64'h5678, 64'h0,
            32'h5, 32'h9, 32'h11, 32'h22);
    expectVisit(64'h5000);
    pulseStart(64'h5000);
    #1;
    chk(!errFlag, "R9", "error cleared", 64'(errFlag), 64'h0);
    waitIdle("R7");

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule